// File: doc/BRIEF.md
# Ping-Pong Event Buffer Sequencer

This block is the control sequencer for a two-bank event buffer. Each bank has two data-block buffers and one interconnect buffer. While the upstream block builders fill one bank, a downstream DMA reader drains the other. For every event the sequencer runs a fixed series of handshakes. It waits for a trigger and captures the interconnect word into the bank being loaded. It waits for the builders and for the DMA reader to go idle. It then swaps the banks through an active-low select byte, pulses a finished strobe, and runs the prepare and error-check handshakes. If the event is marked for transfer, it also waits for a free DMA buffer and starts it.

The builders, the DMA engine and the error checker are outside this block. Each is reached through a request/acknowledge pair or a level input. Two waits carry programmable cycle limits: the DMA-idle wait and the free-buffer wait. When a limit expires, a sticky error flag is set and the sequence moves on. The banks alternate from one event to the next for as long as the block runs. A status pair, made of the bank and the phase code, exposes the ordering.

Top module: `pingpong_evt_seq`

## Requirements
- R1: After reset the following hold:
  - `bufSelN` is 0xD5, which means bank 0 is loading and bank 1 is reading.
  - `curBank` is 0 and `phase` is 0.
  - `finPulse`, every request output and both error flags are low.
- R2: The sequencer stays in phase 0 until `startList` or `slaveReady` is high. Either one starts an event. On that edge, `icData` is captured into the interconnect buffer of bank `curBank` (`icBuf0` or `icBuf1`), and the other buffer is left as it was.
- R3: Phase codes are as follows:
  - 0 wait trigger
  - 1 wait build
  - 2 wait DMA idle
  - 3 swap
  - 4 finished
  - 5 prepare
  - 6 error check
  - 7 find free DMA buffer
  - 8 start DMA

  An event visits phases 1 to 6 in that order, and may then visit 7 and 8.
- R4: `bufSelN` changes only at the end of phase 3. It becomes 0xEA when the event's bank is 0, meaning bank 0 is read and bank 1 is loaded. It becomes 0xD5 when the event's bank is 1.
- R5: `finPulse` is high for exactly the one cycle spent in phase 4, and low at every other time.
- R6: Each of `prepReq` (phase 5), `chkReq` (phase 6) and `dmaReq` (phase 8) stays high until its acknowledge is seen. The phase is then left on the next edge.
- R7: Phase 2 is left as soon as `dmaBusy` is low. If `dmaBusy` stays high for `dmaLimit`+1 cycles of the phase, `errDmaEnd` is set and the sequence goes on to phase 3. The flag stays set until reset.
- R8: At the error-check acknowledge, the sequence moves to phase 0 with the bank toggled if `xferEvent` is low. If `xferEvent` is high, it moves to phase 7.
- R9: Phase 7 is left for phase 8 when `dmaFree` is high. If `dmaFree` stays low for `freeLimit`+1 cycles, `errNoFree` is set (sticky), the DMA start is skipped, and the next event begins with the bank toggled.
- R10: `curBank` toggles at the end of every event, so events alternate between the two banks.
- R11: Phase 1 is held for as long as `buildDone` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startList | input | 1 | Event trigger, start-list source |
| slaveReady | input | 1 | Event trigger, slave-ready source |
| icData | input | IC_W | Interconnect word to capture |
| buildDone | input | 1 | Block builders finished |
| dmaBusy | input | 1 | DMA reader still running |
| dmaFree | input | 1 | A free DMA buffer is available |
| xferEvent | input | 1 | Event is marked for transfer |
| dmaLimit | input | TO_W | DMA-idle wait limit in cycles |
| freeLimit | input | TO_W | Free-buffer wait limit in cycles |
| prepAck | input | 1 | Prepare acknowledge |
| chkAck | input | 1 | Error-check acknowledge |
| dmaAck | input | 1 | DMA start acknowledge |
| finPulse | output | 1 | One-cycle finished strobe |
| prepReq | output | 1 | Prepare request |
| chkReq | output | 1 | Error-check request |
| dmaReq | output | 1 | DMA start request |
| bufSelN | output | 8 | Active-low buffer role select |
| icBuf0 | output | IC_W | Bank 0 interconnect buffer |
| icBuf1 | output | IC_W | Bank 1 interconnect buffer |
| curBank | output | 1 | Bank of the current event |
| phase | output | 4 | Current phase code |
| errDmaEnd | output | 1 | Sticky DMA-idle timeout flag |
| errNoFree | output | 1 | Sticky free-buffer timeout flag |

## Verification
Each phase advance lands on the clock edge after its condition is seen. The new select byte appears together with phase 4, one edge after the swap phase, and `finPulse` is high only during that cycle. The scoreboard queues the expected phase codes and select value for each event before triggering it. The monitor samples on the falling edge and pops one entry each time the phase code changes, so it never depends on a fixed latency. Captures, bank toggles and error flags are compared once the phase returns to 0, which comes one edge after the final acknowledge or timeout.

// File: rtl/pps_pkg.sv
package pps_pkg;

  typedef enum logic [3:0] {
    PH_TRIG   = 4'd0,
    PH_BUILD  = 4'd1,
    PH_DMAEND = 4'd2,
    PH_SWAP   = 4'd3,
    PH_FIN    = 4'd4,
    PH_PREP   = 4'd5,
    PH_CHECK  = 4'd6,
    PH_FREE   = 4'd7,
    PH_START  = 4'd8
  } phase_e;

  typedef struct packed {
    logic capture;
    logic swap;
    logic toggleBank;
    logic cntEn;
    logic useFreeLim;
    logic setErrDma;
    logic setErrFree;
  } strobe_t;

  localparam int NBANK = 2;
  localparam logic [7:0] SEL_RD_BANK0 = 8'hEA;
  localparam logic [7:0] SEL_RD_BANK1 = 8'hD5;

endpackage

// File: rtl/pps_ctrl.sv
module pps_ctrl
  import pps_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    trig,
  input  logic    buildDone,
  input  logic    dmaBusy,
  input  logic    dmaFree,
  input  logic    xferEvent,
  input  logic    prepAck,
  input  logic    chkAck,
  input  logic    dmaAck,
  input  logic    timeout,
  output phase_e  phase,
  output strobe_t strb,
  output logic    finPulse,
  output logic    prepReq,
  output logic    chkReq,
  output logic    dmaReq
);

  phase_e nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_TRIG;
    else       phase <= nxt;
  end

  always_comb begin
    nxt      = phase;
    strb     = '0;
    finPulse = 1'b0;
    prepReq  = 1'b0;
    chkReq   = 1'b0;
    dmaReq   = 1'b0;
    case (phase)
      PH_TRIG: begin
        if (trig) begin
          strb.capture = 1'b1;
          nxt = PH_BUILD;
        end
      end
      PH_BUILD: begin
        if (buildDone) nxt = PH_DMAEND;
      end
      PH_DMAEND: begin
        strb.cntEn = 1'b1;
        if (!dmaBusy) begin
          nxt = PH_SWAP;
        end else if (timeout) begin
          strb.setErrDma = 1'b1;
          nxt = PH_SWAP;
        end
      end
      PH_SWAP: begin
        strb.swap = 1'b1;
        nxt = PH_FIN;
      end
      PH_FIN: begin
        finPulse = 1'b1;
        nxt = PH_PREP;
      end
      PH_PREP: begin
        prepReq = 1'b1;
        if (prepAck) nxt = PH_CHECK;
      end
      PH_CHECK: begin
        chkReq = 1'b1;
        if (chkAck) begin
          if (xferEvent) begin
            nxt = PH_FREE;
          end else begin
            strb.toggleBank = 1'b1;
            nxt = PH_TRIG;
          end
        end
      end
      PH_FREE: begin
        strb.cntEn      = 1'b1;
        strb.useFreeLim = 1'b1;
        if (dmaFree) begin
          nxt = PH_START;
        end else if (timeout) begin
          strb.setErrFree = 1'b1;
          strb.toggleBank = 1'b1;
          nxt = PH_TRIG;
        end
      end
      PH_START: begin
        dmaReq = 1'b1;
        if (dmaAck) begin
          strb.toggleBank = 1'b1;
          nxt = PH_TRIG;
        end
      end
      default: nxt = PH_TRIG;
    endcase
  end

  // R2: no trigger keeps the sequencer idle
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_TRIG && !trig) |=> phase == PH_TRIG);

  // R11: builders not done keeps the build wait
  p_build_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_BUILD && !buildDone) |=> phase == PH_BUILD);

  // R5: finished strobe lasts one cycle
  p_fin_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    finPulse |=> !finPulse);

  // R6: requests held until acknowledged
  p_prep_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (prepReq && !prepAck) |=> prepReq);
  p_chk_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (chkReq && !chkAck) |=> chkReq);
  p_dma_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (dmaReq && !dmaAck) |=> dmaReq);

  // R3: the swap is always followed by the finished phase
  p_swap_then_fin_r3: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_SWAP) |=> phase == PH_FIN);

endmodule

// File: rtl/pps_dpath.sv
module pps_dpath
  import pps_pkg::*;
#(
  parameter int IC_W = 16,
  parameter int TO_W = 12
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         strb,
  input  logic [IC_W-1:0] icData,
  input  logic [TO_W-1:0] dmaLimit,
  input  logic [TO_W-1:0] freeLimit,
  output logic            timeout,
  output logic [7:0]      bufSelN,
  output logic [IC_W-1:0] icBuf [NBANK],
  output logic            curBank,
  output logic            errDmaEnd,
  output logic            errNoFree
);

  logic [TO_W-1:0] waitCnt;
  logic [TO_W-1:0] limSel;

  assign limSel  = strb.useFreeLim ? freeLimit : dmaLimit;
  assign timeout = strb.cntEn && (waitCnt == limSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           waitCnt <= '0;
    else if (!strb.cntEn) waitCnt <= '0;
    else if (!timeout)   waitCnt <= waitCnt + 1'b1;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_ic
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                      icBuf[b] <= '0;
      else if (strb.capture && (curBank == 1'(b)))    icBuf[b] <= icData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufSelN   <= SEL_RD_BANK1;
      curBank   <= 1'b0;
      errDmaEnd <= 1'b0;
      errNoFree <= 1'b0;
    end else begin
      if (strb.swap)       bufSelN   <= curBank ? SEL_RD_BANK1 : SEL_RD_BANK0;
      if (strb.toggleBank) curBank   <= ~curBank;
      if (strb.setErrDma)  errDmaEnd <= 1'b1;
      if (strb.setErrFree) errNoFree <= 1'b1;
    end
  end

  // R4: select byte holds one of its two legal codes
  p_sel_legal_r4: assert property (@(posedge clk) disable iff (!rstN)
    (bufSelN == SEL_RD_BANK0) || (bufSelN == SEL_RD_BANK1));

  // R4: select byte moves only on a swap strobe
  p_sel_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.swap |=> $stable(bufSelN));

  // R7 / R9: error flags are sticky
  p_err_dma_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    errDmaEnd |=> errDmaEnd);
  p_err_free_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    errNoFree |=> errNoFree);

endmodule

// File: rtl/pingpong_evt_seq.sv
module pingpong_evt_seq
  import pps_pkg::*;
#(
  parameter int IC_W = 16,
  parameter int TO_W = 12
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startList,
  input  logic            slaveReady,
  input  logic [IC_W-1:0] icData,
  input  logic            buildDone,
  input  logic            dmaBusy,
  input  logic            dmaFree,
  input  logic            xferEvent,
  input  logic [TO_W-1:0] dmaLimit,
  input  logic [TO_W-1:0] freeLimit,
  input  logic            prepAck,
  input  logic            chkAck,
  input  logic            dmaAck,
  output logic            finPulse,
  output logic            prepReq,
  output logic            chkReq,
  output logic            dmaReq,
  output logic [7:0]      bufSelN,
  output logic [IC_W-1:0] icBuf0,
  output logic [IC_W-1:0] icBuf1,
  output logic            curBank,
  output logic [3:0]      phase,
  output logic            errDmaEnd,
  output logic            errNoFree
);

  strobe_t         strb;
  phase_e          phaseQ;
  logic            timeout;
  logic [IC_W-1:0] icBuf [NBANK];

  pps_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .trig      (startList | slaveReady),
    .buildDone (buildDone),
    .dmaBusy   (dmaBusy),
    .dmaFree   (dmaFree),
    .xferEvent (xferEvent),
    .prepAck   (prepAck),
    .chkAck    (chkAck),
    .dmaAck    (dmaAck),
    .timeout   (timeout),
    .phase     (phaseQ),
    .strb      (strb),
    .finPulse  (finPulse),
    .prepReq   (prepReq),
    .chkReq    (chkReq),
    .dmaReq    (dmaReq)
  );

  pps_dpath #(.IC_W(IC_W), .TO_W(TO_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .icData    (icData),
    .dmaLimit  (dmaLimit),
    .freeLimit (freeLimit),
    .timeout   (timeout),
    .bufSelN   (bufSelN),
    .icBuf     (icBuf),
    .curBank   (curBank),
    .errDmaEnd (errDmaEnd),
    .errNoFree (errNoFree)
  );

  assign phase  = phaseQ;
  assign icBuf0 = icBuf[0];
  assign icBuf1 = icBuf[1];

endmodule

// File: tb/sim_pingpong_evt_seq.sv
module sim_pingpong_evt_seq;
  localparam int CLK_PERIOD = 10;
  localparam int IC_W = 16;
  localparam int TO_W = 12;

  logic clk = 0, rstN = 0;
  logic startList = 0, slaveReady = 0, buildDone = 0, dmaBusy = 0, dmaFree = 0, xferEvent = 0;
  logic prepAck = 0, chkAck = 0, dmaAck = 0;
  logic [IC_W-1:0] icData = '0;
  logic [TO_W-1:0] dmaLimit = 12'd5, freeLimit = 12'd4;
  logic finPulse, prepReq, chkReq, dmaReq, curBank, errDmaEnd, errNoFree;
  logic [7:0] bufSelN;
  logic [IC_W-1:0] icBuf0, icBuf1;
  logic [3:0] phase;

  int checks = 0, errors = 0, cycles = 0;
  bit buildGo = 1, started = 0;
  int expPhase[$];
  logic [7:0] expSel[$];
  logic expBank = 0, expErrDma = 0, expErrFree = 0;
  logic [IC_W-1:0] expIc0 = '0, expIc1 = '0;

  pingpong_evt_seq #(.IC_W(IC_W), .TO_W(TO_W)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // responders: acknowledge one cycle after a request is seen
  initial forever begin
    logic p, c, d, b;
    @(negedge clk);
    p = prepReq; c = chkReq; d = dmaReq; b = (phase == 4'd1) && buildGo;
    @(posedge clk); #1;
    prepAck = p; chkAck = c; dmaAck = d; buildDone = b;
  end

  // monitor: pops expected phases on every phase change
  initial begin
    logic [3:0] last = 4'd0;
    forever begin
      @(negedge clk);
      if (started) begin
        chk("R5 finPulse", finPulse, phase == 4'd4);
        if (phase != last) begin
          if (expPhase.size() == 0) chk("R3 unexpected phase", phase, 4'hF);
          else chk("R3 phase order", phase, expPhase.pop_front());
          if (phase == 4'd4) begin
            if (expSel.size() == 0) chk("R4 unexpected swap", bufSelN, 0);
            else chk("R4 select byte", bufSelN, expSel.pop_front());
          end
          last = phase;
        end
      end
    end
  end

  // watchdog
  initial begin
    while (cycles < 20000) begin @(posedge clk); cycles++; end
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic run_event(bit useSlave, logic [IC_W-1:0] d, bit xfer, bit busy, bit free);
    bit tmoDma = busy, tmoFree = xfer && !free;
    expPhase.push_back(1); expPhase.push_back(2); expPhase.push_back(3);
    expPhase.push_back(4); expPhase.push_back(5); expPhase.push_back(6);
    if (xfer) begin
      expPhase.push_back(7);
      if (!tmoFree) expPhase.push_back(8);
    end
    expPhase.push_back(0);
    expSel.push_back(expBank ? 8'hD5 : 8'hEA);
    @(posedge clk); #1;
    dmaBusy = busy; dmaFree = free; xferEvent = xfer; icData = d;
    if (useSlave) slaveReady = 1; else startList = 1;
    @(posedge clk); #1;
    slaveReady = 0; startList = 0;
    do @(negedge clk); while (phase != 4'd0);
    if (expBank) expIc1 = d; else expIc0 = d;
    expBank = ~expBank;
    if (tmoDma) expErrDma = 1;
    if (tmoFree) expErrFree = 1;
    chk("R2 icBuf0", icBuf0, expIc0);
    chk("R2 icBuf1", icBuf1, expIc1);
    chk("R10 bank toggle", curBank, expBank);
    chk("R7 errDmaEnd", errDmaEnd, expErrDma);
    chk("R9 errNoFree", errNoFree, expErrFree);
    chk("R6 prepReq idle", prepReq, 0);
    dmaBusy = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 select", bufSelN, 8'hD5);
    chk("R1 phase", phase, 0);
    chk("R1 bank", curBank, 0);
    chk("R1 reqs", {finPulse, prepReq, chkReq, dmaReq}, 0);
    chk("R1 flags", {errDmaEnd, errNoFree}, 0);
    @(posedge clk); #1 rstN = 1;
    started = 1;
    repeat (3) @(negedge clk);
    chk("R2 idle without trigger", phase, 0);

    run_event(0, 16'hA5A5, 0, 0, 0);  // R8 skip transfer, bank 0
    run_event(1, 16'h3C3C, 1, 0, 1);  // R6 full DMA start, bank 1
    run_event(0, 16'h1111, 1, 1, 1);  // R7 DMA-idle timeout

    // R11: hold the builders back
    buildGo = 0;
    expPhase.push_back(1); expPhase.push_back(2); expPhase.push_back(3);
    expPhase.push_back(4); expPhase.push_back(5); expPhase.push_back(6);
    expPhase.push_back(0);
    expSel.push_back(expBank ? 8'hD5 : 8'hEA);
    @(posedge clk); #1; xferEvent = 0; icData = 16'h7E7E; slaveReady = 1;
    @(posedge clk); #1; slaveReady = 0;
    repeat (8) @(negedge clk);
    chk("R11 build wait", phase, 1);
    buildGo = 1;
    do @(negedge clk); while (phase != 4'd0);
    expIc1 = 16'h7E7E; expBank = ~expBank;
    chk("R10 bank after held event", curBank, expBank);
    chk("R2 capture after held event", icBuf1, expIc1);

    run_event(1, 16'hBEEF, 1, 0, 0);  // R9 free-buffer timeout
    run_event(0, 16'h0F0F, 0, 0, 0);  // R7 R9 flags stay sticky
    chk("R3 queue drained", expPhase.size(), 0);
    finish_run();
  end
endmodule